// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block fills a serial configuration chain once each time reset is released, and then presents the decoded setup fields of a clock generator. The chain is 18 bits long in the base build and 19 bits long in the extended build, where an extra deskew-disable bit is added. The bits can come from one of three sources. A host can clock them in on a strobe pin. A small built-in table can supply one of eight preset words. A serial EEPROM reader can stream them in with a per-bit valid. The source is chosen by a tri-level mode pin, and the pin is sampled only once, on the first clock after reset is released.

A load always takes exactly the chain length in captured bits. Once the last bit is in, a valid flag rises on the following clock and the fields are frozen until the next reset. Later strobe edges, later stream bits and later changes on the mode pin or the selection pins have no effect. Asserting reset at any point empties the chain, and a new load must follow.

Top module: `cfg_loader`

## Requirements
- R1: While `rst` is high and until a load completes, `cfg_valid` is 0 and every field output (`n_o`, `r_o`, `ddsk_o`, `cm_o`, `cs_o`, `test_o`, `m_o`) reads 0.
- R2: On the first clock after `rst` falls, `mode_pin` selects the source: 2'b00 preset table, 2'b01 host strobe, 2'b10 or 2'b11 EEPROM stream. The ROM code `{sel_msb, sclk_in, sdata_in}` is taken in the same cycle. Changes on these pins after that cycle have no effect until the next reset.
- R3: Base build (`EXT_DDSK`=0), 18 bits. Taken as a word whose MSB is the first bit on the wire, the load is `{M[5:0], TEST, CS, CM, R[1:0], N[6:0]}`. M5 arrives first and N0 arrives last.
- R4: Extended build (`EXT_DDSK`=1), 19 bits. The word is `{M[5:0], TEST, CS, CM, DDSK, R[1:0], N[6:0]}`, so DDSK sits between R1 and CM. In the base build `ddsk_o` is always 0.
- R5: In host mode, `sdata_in` is captured on each rising edge of `sclk_in` seen by `clk` (low on one sample, high on the next). Only the first 18 or 19 edges after release count. Once the load is complete, further edges leave every output unchanged.
- R6: In preset mode the 3-bit code selects the word. Codes 0 to 3 give CS=1, codes 4 to 7 give CS=0. Codes 0 to 2 give CM=1, all others CM=0. Only code 7 gives TEST=1, and code 7 has M, N and R at 0. DDSK is 0 for every code.
- R7: In preset mode, codes 0, 3 and 4 give M=0, N=0. Codes 1 and 5 give M=5, N=2. Codes 2 and 6 give M=2, N=5. In the base build R is 2'b10 for codes 1 and 5 and 2'b01 for the other codes below 7. In the extended build R is 2'b01 for codes 1 and 5 and 2'b00 for all others.
- R8: In EEPROM mode, `ee_bit` is captured on each clock where `ee_valid` is high, until the chain is full. Gaps of any length between bits are allowed.
- R9: `cfg_valid` rises on the clock after the one that captures the last bit, and stays high until reset. In preset mode one bit is captured per clock from the first clock after release, so valid is first seen after chain length plus one rising edges.
- R10: Asserting `rst` clears a completed or partial load. After release, a full new load gives the new word with no bits left over from before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; a load starts when it falls |
| mode_pin | input | 2 | Source select level: 00 low, 01 high, 10/11 floating |
| sel_msb | input | 1 | Preset code bit 2 |
| sclk_in | input | 1 | Host strobe; also preset code bit 1 |
| sdata_in | input | 1 | Host data; also preset code bit 0 |
| ee_valid | input | 1 | EEPROM reader bit strobe |
| ee_bit | input | 1 | EEPROM reader data bit |
| n_o | output | 7 | Feedback divider field |
| r_o | output | 2 | Output range field |
| ddsk_o | output | 1 | Deskew disable (extended build only) |
| cm_o | output | 1 | Cascade reference select |
| cs_o | output | 1 | Input clock type select |
| test_o | output | 1 | Bypass test mode |
| m_o | output | 6 | Reference divider field |
| cfg_valid | output | 1 | Configuration loaded |

## Verification
A base and an extended instance run side by side. All eight preset codes are swept on both, which separates the CS/CM/TEST grouping from the ratio grouping of M, N and R and shows the different R encoding of the two builds. Host and EEPROM loads use words with an asymmetric pattern, alternating bits and all ones, so a reversed wire order or a field shifted by one place (DDSK in particular) shows up as a wrong field. Extra strobes after a complete load, pin changes right after release, and a reset in the middle of a load show whether the counter stops, the source is latched once, and the chain is cleared. Valid is sampled exactly one clock before and one clock after its expected rise.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int CHAIN_MAX = 19;
    localparam int N_W       = 7;
    localparam int R_W       = 2;
    localparam int M_W       = 6;
    localparam int CODE_W    = 3;
    localparam int N_PRESETS = 8;

    typedef enum logic [1:0] {
        SRC_ROM  = 2'b00,
        SRC_AUX  = 2'b01,
        SRC_MAIN = 2'b10
    } src_e;

    typedef struct packed {
        logic [N_W-1:0] n;
        logic [R_W-1:0] r;
        logic           ddsk;
        logic           cm;
        logic           cs;
        logic           test;
        logic [M_W-1:0] m;
    } cfg_t;

    function automatic src_e pin_to_src(input logic [1:0] lvl);
        case (lvl)
            2'b00:   return SRC_ROM;
            2'b01:   return SRC_AUX;
            default: return SRC_MAIN;
        endcase
    endfunction

    // Chain vector: index 0 is the serial-in end (N0), upper end is M5.
    function automatic logic [CHAIN_MAX-1:0] pack_chain(input cfg_t c, input bit ext);
        logic [CHAIN_MAX-1:0] v;
        v = '0;
        v[6:0] = c.n;
        v[8:7] = c.r;
        if (ext) begin
            v[9]     = c.ddsk;
            v[10]    = c.cm;
            v[11]    = c.cs;
            v[12]    = c.test;
            v[18:13] = c.m;
        end else begin
            v[9]     = c.cm;
            v[10]    = c.cs;
            v[11]    = c.test;
            v[17:12] = c.m;
        end
        return v;
    endfunction

    function automatic cfg_t unpack_chain(input logic [CHAIN_MAX-1:0] v, input bit ext);
        cfg_t c;
        c.n = v[6:0];
        c.r = v[8:7];
        if (ext) begin
            c.ddsk = v[9];
            c.cm   = v[10];
            c.cs   = v[11];
            c.test = v[12];
            c.m    = v[18:13];
        end else begin
            c.ddsk = 1'b0;
            c.cm   = v[9];
            c.cs   = v[10];
            c.test = v[11];
            c.m    = v[17:12];
        end
        return c;
    endfunction

    function automatic cfg_t preset(input logic [CODE_W-1:0] code, input bit ext);
        cfg_t c;
        c      = '0;
        c.cs   = (code < 3'd4);
        c.cm   = (code < 3'd3);
        c.test = (code == 3'd7);
        case (code)
            3'd1, 3'd5: begin
                c.m = 6'd5;
                c.n = 7'd2;
                c.r = ext ? 2'b01 : 2'b10;
            end
            3'd2, 3'd6: begin
                c.m = 6'd2;
                c.n = 7'd5;
                c.r = ext ? 2'b00 : 2'b01;
            end
            3'd7: begin
                c.m = '0;
                c.n = '0;
                c.r = '0;
            end
            default: begin
                c.m = '0;
                c.n = '0;
                c.r = ext ? 2'b00 : 2'b01;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cfg_src_latch.sv
module cfg_src_latch
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_pin,
    input  logic [CODE_W-1:0] code_pins,
    output src_e              src_eff,
    output logic [CODE_W-1:0] code_eff,
    output logic              armed
);

    src_e              src_q;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            src_q  <= SRC_ROM;
            code_q <= '0;
        end else if (!armed) begin
            armed  <= 1'b1;
            src_q  <= pin_to_src(mode_pin);
            code_q <= code_pins;
        end
    end

    // First cycle after release uses the live pins; afterwards the latched copy.
    assign src_eff  = armed ? src_q  : pin_to_src(mode_pin);
    assign code_eff = armed ? code_q : code_pins;

endmodule

// File: rtl/cfg_preset_rom.sv
module cfg_preset_rom
    import cfg_pkg::*;
#(
    parameter bit EXT_DDSK = 1'b0,
    localparam int W = EXT_DDSK ? 19 : 18
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [W-1:0]      word_o
);

    logic [W-1:0] tbl [N_PRESETS];

    for (genvar g = 0; g < N_PRESETS; g++) begin : g_entry
        assign tbl[g] = W'(pack_chain(preset(CODE_W'(g), EXT_DDSK), EXT_DDSK));
    end

    assign word_o = tbl[code_i];

endmodule

// File: rtl/cfg_capture.sv
module cfg_capture
    import cfg_pkg::*;
#(
    parameter int W = 18,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  src_e         src,
    input  logic [W-1:0] rom_word,
    input  logic         sclk_in,
    input  logic         sdata_in,
    input  logic         ee_valid,
    input  logic         ee_bit,
    output logic [W-1:0] chain,
    output logic         full,
    output logic         cap_fire
);

    logic          sclk_q;
    logic [CW-1:0] cnt;
    logic          room;
    logic          take;
    logic          nbit;
    int            rom_idx;

    assign room    = (cnt < CW'(W));
    assign rom_idx = room ? (W - 1 - int'(cnt)) : 0;

    always_comb begin
        case (src)
            SRC_AUX: begin
                take = sclk_in & ~sclk_q;
                nbit = sdata_in;
            end
            SRC_MAIN: begin
                take = ee_valid;
                nbit = ee_bit;
            end
            default: begin
                take = 1'b1;
                nbit = rom_word[rom_idx];
            end
        endcase
    end

    assign cap_fire = take & room;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b1;
            cnt    <= '0;
            chain  <= '0;
        end else begin
            sclk_q <= sclk_in;
            if (cap_fire) begin
                chain <= {chain[W-2:0], nbit};
                cnt   <= cnt + CW'(1);
            end
        end
    end

    assign full = (cnt == CW'(W));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_pkg::*;
#(
    parameter bit EXT_DDSK = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pin,
    input  logic       sel_msb,
    input  logic       sclk_in,
    input  logic       sdata_in,
    input  logic       ee_valid,
    input  logic       ee_bit,
    output logic [6:0] n_o,
    output logic [1:0] r_o,
    output logic       ddsk_o,
    output logic       cm_o,
    output logic       cs_o,
    output logic       test_o,
    output logic [5:0] m_o,
    output logic       cfg_valid
);

    localparam int W = EXT_DDSK ? 19 : 18;

    src_e              src_eff;
    logic [CODE_W-1:0] code_eff;
    logic              armed;
    logic [W-1:0]      rom_word;
    logic [W-1:0]      chain;
    logic              full;
    logic              cap_fire;
    cfg_t              cfg_dec;

    cfg_src_latch u_src (
        .clk       (clk),
        .rst       (rst),
        .mode_pin  (mode_pin),
        .code_pins ({sel_msb, sclk_in, sdata_in}),
        .src_eff   (src_eff),
        .code_eff  (code_eff),
        .armed     (armed)
    );

    cfg_preset_rom #(.EXT_DDSK(EXT_DDSK)) u_rom (
        .code_i (code_eff),
        .word_o (rom_word)
    );

    cfg_capture #(.W(W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .src      (src_eff),
        .rom_word (rom_word),
        .sclk_in  (sclk_in),
        .sdata_in (sdata_in),
        .ee_valid (ee_valid),
        .ee_bit   (ee_bit),
        .chain    (chain),
        .full     (full),
        .cap_fire (cap_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) cfg_valid <= 1'b0;
        else     cfg_valid <= full;
    end

    assign cfg_dec = cfg_valid ? unpack_chain(CHAIN_MAX'(chain), EXT_DDSK) : '0;

    assign n_o    = cfg_dec.n;
    assign r_o    = cfg_dec.r;
    assign ddsk_o = cfg_dec.ddsk;
    assign cm_o   = cfg_dec.cm;
    assign cs_o   = cfg_dec.cs;
    assign test_o = cfg_dec.test;
    assign m_o    = cfg_dec.m;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
    parameter int W = 18,
    localparam int SW = $clog2(W + 1) + 1
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_valid,
    input logic        cap_fire,
    input logic        armed,
    input logic [1:0]  src,
    input logic [19:0] cfg_word
);

    logic [SW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)           seen <= '0;
        else if (cap_fire) seen <= seen + SW'(1);
    end

    AST_RST_CLEARS_VALID: assert property (@(posedge clk) rst |=> !cfg_valid); // R10

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> cfg_valid); // R9

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> $stable(cfg_word)); // R5

    AST_NO_OVERCAPTURE: assert property (@(posedge clk) disable iff (rst)
        cap_fire |-> (seen < SW'(W))); // R5

    AST_VALID_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_valid) |-> (seen == SW'(W))); // R9

    AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (rst)
        armed |=> $stable(src)); // R2

endmodule

bind cfg_loader cfg_loader_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_valid (cfg_valid),
    .cap_fire  (cap_fire),
    .armed     (armed),
    .src       (src_eff),
    .cfg_word  ({n_o, r_o, ddsk_o, cm_o, cs_o, test_o, m_o})
);

// File: tb/cfg_loader_tb.sv
`timescale 1ns/1ps
module cfg_loader_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic [1:0] mode_pin = 2'b00;
    logic       sel_msb = 1'b0;
    logic       sclk = 1'b0, sdat = 1'b0, eev = 1'b0, eeb = 1'b0;
    logic       xsclk = 1'b0, xsdat = 1'b0, xeev = 1'b0, xeeb = 1'b0;

    logic [6:0] n_o, xn;
    logic [1:0] r_o, xr;
    logic       ddsk_o, cm_o, cs_o, test_o, valid;
    logic       xddsk, xcm, xcs, xtest, xvalid;
    logic [5:0] m_o, xm;

    cfg_loader #(.EXT_DDSK(1'b0)) u_dut (
        .clk(clk), .rst(rst), .mode_pin(mode_pin), .sel_msb(sel_msb),
        .sclk_in(sclk), .sdata_in(sdat), .ee_valid(eev), .ee_bit(eeb),
        .n_o(n_o), .r_o(r_o), .ddsk_o(ddsk_o), .cm_o(cm_o), .cs_o(cs_o),
        .test_o(test_o), .m_o(m_o), .cfg_valid(valid)
    );

    cfg_loader #(.EXT_DDSK(1'b1)) u_dut_ext (
        .clk(clk), .rst(rst), .mode_pin(mode_pin), .sel_msb(sel_msb),
        .sclk_in(xsclk), .sdata_in(xsdat), .ee_valid(xeev), .ee_bit(xeeb),
        .n_o(xn), .r_o(xr), .ddsk_o(xddsk), .cm_o(xcm), .cs_o(xcs),
        .test_o(xtest), .m_o(xm), .cfg_valid(xvalid)
    );

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] base_out();
        return {1'b0, m_o, test_o, cs_o, cm_o, r_o, n_o};
    endfunction

    function automatic logic [18:0] ext_out();
        return {xm, xtest, xcs, xcm, xddsk, xr, xn};
    endfunction

    // Expected preset word, MSB = first bit on the wire
    function automatic logic [18:0] preset_word(input int code, input bit ext);
        bit half, dbl, tst, cs, cm;
        logic [5:0] m;
        logic [6:0] n;
        logic [1:0] r;
        half = (code == 1) || (code == 5);
        dbl  = (code == 2) || (code == 6);
        tst  = (code == 7);
        cs   = (code <= 3);
        cm   = (code <= 2);
        m    = half ? 6'd5 : (dbl ? 6'd2 : 6'd0);
        n    = half ? 7'd2 : (dbl ? 7'd5 : 7'd0);
        if (ext) r = half ? 2'b01 : 2'b00;
        else     r = tst ? 2'b00 : (half ? 2'b10 : 2'b01);
        return ext ? {m, tst, cs, cm, 1'b0, r, n} : {1'b0, m, tst, cs, cm, r, n};
    endfunction

    task automatic do_reset(input logic [1:0] mode, input int code);
        @(negedge clk);
        rst = 1'b1;
        mode_pin = mode;
        sel_msb = code[2];
        sclk = code[1]; sdat = code[0];
        xsclk = code[1]; xsdat = code[0];
        eev = 1'b0; xeev = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic aux_send(input logic [18:0] w, input int nb, input bit ext);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            if (ext) begin xsclk = 1'b0; xsdat = w[nb-1-i]; end
            else     begin sclk  = 1'b0; sdat  = w[nb-1-i]; end
            @(negedge clk);
            if (ext) xsclk = 1'b1; else sclk = 1'b1;
        end
    endtask

    task automatic main_send(input logic [18:0] w, input int nb, input bit ext);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            if (ext) begin xeev = 1'b1; xeeb = w[nb-1-i]; xsclk = i[0]; end
            else     begin eev  = 1'b1; eeb  = w[nb-1-i]; sclk  = i[0]; end
            if (i % 3 == 1) begin
                @(negedge clk);
                if (ext) xeev = 1'b0; else eev = 1'b0;
                @(negedge clk);
            end
        end
        @(negedge clk);
        eev = 1'b0; xeev = 1'b0;
    endtask

    logic [18:0] pats [3];

    initial begin
        pats[0] = 19'h2D6B3;
        pats[1] = 19'h55555;
        pats[2] = 19'h7FFFF;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 valid in reset", valid, 0);
        chk("R1 fields in reset", base_out(), 0);
        chk("R1 ext fields in reset", ext_out(), 0);

        // R6 R7 R9: preset sweep on both builds
        for (int c = 0; c < 8; c++) begin
            do_reset(2'b00, c);
            repeat (18) @(posedge clk);
            @(negedge clk);
            chk("R9 base valid early", valid, 0);
            chk("R1 fields before valid", base_out(), 0);
            @(negedge clk);
            chk("R9 base valid on time", valid, 1);
            chk("R9 ext valid early", xvalid, 0);
            @(negedge clk);
            chk("R9 ext valid on time", xvalid, 1);
            chk("R6 R7 base preset", base_out(), preset_word(c, 1'b0));
            chk("R6 R7 ext preset", ext_out(), preset_word(c, 1'b1));
        end

        // R2: pins changed after the latch cycle have no effect
        do_reset(2'b00, 2);
        @(negedge clk);
        mode_pin = 2'b01; sel_msb = 1'b1; sclk = 1'b0; sdat = 1'b1;
        xsclk = 1'b0; xsdat = 1'b1;
        repeat (25) @(negedge clk);
        chk("R2 latched preset base", base_out(), preset_word(2, 1'b0));
        chk("R2 latched preset ext", ext_out(), preset_word(2, 1'b1));

        // R3 R4 R5: host strobe loads
        for (int p = 0; p < 3; p++) begin
            do_reset(2'b01, 0);
            aux_send(pats[p], 18, 1'b0);
            @(negedge clk);
            chk("R9 aux valid one clock after last bit", valid, 0);
            @(negedge clk);
            chk("R9 aux valid rises", valid, 1);
            chk("R3 base word order", base_out(), {1'b0, pats[p][17:0]});
            chk("R5 ext untouched", xvalid, 0);
            aux_send(~pats[p], 4, 1'b0);
            repeat (2) @(negedge clk);
            chk("R5 late edges ignored", base_out(), {1'b0, pats[p][17:0]});

            do_reset(2'b01, 0);
            aux_send(pats[p], 19, 1'b1);
            repeat (2) @(negedge clk);
            chk("R4 ext word with DDSK", ext_out(), pats[p]);
            chk("R4 base ddsk zero", {31'd0, ddsk_o}, 0);
        end

        // R8: EEPROM stream with gaps, both float encodings
        do_reset(2'b10, 0);
        main_send(pats[0], 18, 1'b0);
        main_send(pats[1], 19, 1'b1);
        repeat (2) @(negedge clk);
        chk("R8 main base", base_out(), {1'b0, pats[0][17:0]});
        chk("R8 main ext", ext_out(), pats[1]);
        do_reset(2'b11, 0);
        main_send(pats[2] ^ 19'h0F0F0, 18, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8 R2 mode 11 is stream", base_out(), {1'b0, pats[2][17:0] ^ 18'h0F0F0});

        // R10: reset clears, partial load discarded
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 reset clears valid", valid, 0);
        chk("R10 reset clears fields", base_out(), 0);
        do_reset(2'b01, 0);
        aux_send(19'h3FFFF, 10, 1'b0);
        do_reset(2'b01, 0);
        aux_send(pats[0], 18, 1'b0);
        repeat (2) @(negedge clk);
        chk("R10 reload after partial", base_out(), {1'b0, pats[0][17:0]});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule